// File: doc/BRIEF.md
# Periodic Drive Status Responder

This block is the drive end of a four-bit handshake link between an optical drive controller and its host. Once in every 75 Hz period it can offer a ten-nibble status frame to the host. When the host has read that frame it answers with a ten-nibble command frame. The drive raises its active-low ready request only when a period tick arrives and the host has answered the previous frame. If the host stops answering, the periodic requests stop, and so do the host's periodic interrupts.

Each status frame carries a reported status code in its first nibble. The next eight nibbles are zero. The last nibble is a checksum. The block keeps two codes:

- the drive code, which is the drive's own condition;
- the reported code, which is what goes out in the frame.

A no-operation command copies the drive code into the reported code. A stop command sets both codes to stopped. After a parameterised number of periods, the drive code moves to "reading table of contents" if a disc is present, or to "no disc" if none is present.

Each nibble on the link is paced by the host strobe. The drive presents each status nibble with its own strobe high. It moves on only at a falling edge of the host strobe. Command nibbles are taken at the same falling edges.

Top module: `drv_status_responder`

## Requirements
- R1: After reset, rdy_req_n is 1, drv_strobe is 0 and stat_nib is 0. The reported code is 0x0 and the drive code is 0xB (no disc), so the first frame is nine zero nibbles followed by 0xF.
- R2: rdy_req_n goes low in the cycle after a period_tick pulse seen while the link is idle and a reply has arrived. After reset this counts as a reply having arrived. rdy_req_n never goes low at any other time.
- R3: If no complete command frame has been received since the last status frame was requested, period ticks raise no request.
- R4: The first host_strobe falling edge after a request returns rdy_req_n high and presents status nibble 0 with drv_strobe high. Each later falling edge advances to the next nibble. A high or rising host_strobe does not advance the frame. The falling edge after nibble 9 ends the status frame.
- R5: Nibbles 1 to 8 of a status frame are 0. Nibble 9 equals the bitwise inverse of the low four bits of the sum of nibbles 0 to 8.
- R6: After a status frame, cmd_nib is captured at each of ten host_strobe falling edges. The first captured nibble is the opcode, and it is acted on once the tenth nibble arrives. The other nine nibbles, including the command checksum, have no effect.
- R7: An opcode other than 0x1 (0x0 is the no-operation) copies the drive code into the reported code. The drive code is left unchanged.
- R8: Opcode 0x1 (stop) sets both the reported code and the drive code to 0x0.
- R9: After a stop, the HOLD_PERIODS-th period_tick moves the drive code to 0x9 if disc_present is 1, or to 0xB if disc_present is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse at the start of each 75 Hz period |
| disc_present | input | 1 | High when a disc is loaded |
| host_strobe | input | 1 | Host handshake strobe; its falling edges pace the link |
| cmd_nib | input | 4 | Command nibble driven by the host |
| rdy_req_n | output | 1 | Active-low request to send a status frame |
| drv_strobe | output | 1 | High while a status nibble is presented |
| stat_nib | output | 4 | Status nibble; 0 when no nibble is presented |

## Verification
The link is exercised in three ways. A steady cadence of frame and reply tells request pacing apart from eager requests. Silent host periods check that requests stop without a reply. A strobe held high mid-frame separates edge pacing from level pacing. The stop command is applied with a disc present and with none, and it carries a deliberately wrong command checksum. Frames are then read across the hold periods, which tells the two follow-up codes apart and exposes a hold that is too short or too long. A non-stop, non-zero opcode with stray data in the later nibbles shows that only the first nibble is decoded.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [3:0] {
        CODE_STOPPED = 4'h0,
        CODE_TOC     = 4'h9,
        CODE_NODISC  = 4'hB
    } drv_code_e;

    typedef enum logic [3:0] {
        OP_NOP  = 4'h0,
        OP_STOP = 4'h1
    } drv_op_e;

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_REQ,
        LNK_SEND,
        LNK_RECV
    } link_state_e;

    typedef struct packed {
        link_state_e st;
        logic        may_req;
        logic        hs_q;
    } link_regs_t;

    function automatic logic [3:0] frame_csum(input logic [7:0] sum);
        return ~sum[3:0];
    endfunction

    function automatic logic [3:0] follow_code(input logic disc);
        return disc ? CODE_TOC : CODE_NODISC;
    endfunction

endpackage

// File: rtl/dsr_link_fsm.sv
module dsr_link_fsm
    import dsr_pkg::*;
#(
    parameter int FRAME_LEN = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         period_tick,
    input  logic                         host_strobe,
    input  logic [3:0]                   cmd_nib,
    output logic                         rdy_req_n,
    output logic                         drv_strobe,
    output logic [$clog2(FRAME_LEN)-1:0] idx,
    output logic                         hs_fall,
    output logic                         cmd_done,
    output logic [3:0]                   cmd_op
);
    localparam int IW = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

    link_regs_t r;

    assign hs_fall    = r.hs_q & ~host_strobe;
    assign rdy_req_n  = (r.st != LNK_REQ);
    assign drv_strobe = (r.st == LNK_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            r.st      <= LNK_IDLE;
            r.may_req <= 1'b1;
            r.hs_q    <= 1'b0;
            idx       <= '0;
            cmd_done  <= 1'b0;
            cmd_op    <= 4'h0;
        end else begin
            r.hs_q   <= host_strobe;
            cmd_done <= 1'b0;
            unique case (r.st)
                LNK_IDLE: begin
                    if (period_tick && r.may_req) begin
                        r.st      <= LNK_REQ;
                        r.may_req <= 1'b0;
                    end
                end
                LNK_REQ: begin
                    if (hs_fall) begin
                        r.st <= LNK_SEND;
                        idx  <= '0;
                    end
                end
                LNK_SEND: begin
                    if (hs_fall) begin
                        if (idx == LAST) begin
                            r.st <= LNK_RECV;
                            idx  <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                LNK_RECV: begin
                    if (hs_fall) begin
                        if (idx == '0) cmd_op <= cmd_nib;
                        if (idx == LAST) begin
                            r.st      <= LNK_IDLE;
                            r.may_req <= 1'b1;
                            cmd_done  <= 1'b1;
                            idx       <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: r.st <= LNK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dsr_code_tracker.sv
module dsr_code_tracker
    import dsr_pkg::*;
#(
    parameter int HOLD_PERIODS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       period_tick,
    input  logic       disc_present,
    input  logic       cmd_done,
    input  logic [3:0] cmd_op,
    output logic [3:0] rep_code,
    output logic [3:0] drv_code
);
    localparam int CW = $clog2(HOLD_PERIODS + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_PERIODS);

    logic [CW-1:0] hold_cnt;
    logic          is_stop;

    assign is_stop = cmd_done && (cmd_op == OP_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_code <= CODE_STOPPED;
            drv_code <= CODE_NODISC;
            hold_cnt <= '0;
        end else if (is_stop) begin
            rep_code <= CODE_STOPPED;
            drv_code <= CODE_STOPPED;
            hold_cnt <= HOLD;
        end else begin
            if (cmd_done) rep_code <= drv_code;
            if (period_tick && hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
                if (hold_cnt == CW'(1)) drv_code <= follow_code(disc_present);
            end
        end
    end
endmodule

// File: rtl/dsr_frame_gen.sv
module dsr_frame_gen
    import dsr_pkg::*;
#(
    parameter int FRAME_LEN = 10
) (
    input  logic                         en,
    input  logic [3:0]                   rep_code,
    input  logic [$clog2(FRAME_LEN)-1:0] idx,
    output logic [3:0]                   nib
);
    logic [3:0] frame [FRAME_LEN];
    logic [7:0] sum;

    assign frame[0] = rep_code;

    for (genvar g = 1; g < FRAME_LEN - 1; g++) begin : g_fill
        assign frame[g] = 4'h0;
    end

    always_comb begin
        sum = 8'h0;
        for (int i = 0; i < FRAME_LEN - 1; i++) sum = sum + {4'h0, frame[i]};
    end

    assign frame[FRAME_LEN-1] = frame_csum(sum);

    always_comb begin
        nib = 4'h0;
        if (en && 32'(idx) < FRAME_LEN) nib = frame[idx];
    end
endmodule

// File: rtl/drv_status_responder.sv
module drv_status_responder
    import dsr_pkg::*;
#(
    parameter int FRAME_LEN    = 10,
    parameter int HOLD_PERIODS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       period_tick,
    input  logic       disc_present,
    input  logic       host_strobe,
    input  logic [3:0] cmd_nib,
    output logic       rdy_req_n,
    output logic       drv_strobe,
    output logic [3:0] stat_nib
);
    logic [$clog2(FRAME_LEN)-1:0] idx;
    logic                         hs_fall;
    logic                         cmd_done;
    logic [3:0]                   cmd_op;
    logic [3:0]                   rep_code;
    logic [3:0]                   drv_code;

    dsr_link_fsm #(.FRAME_LEN(FRAME_LEN)) u_link (
        .clk(clk), .rst(rst), .period_tick(period_tick),
        .host_strobe(host_strobe), .cmd_nib(cmd_nib),
        .rdy_req_n(rdy_req_n), .drv_strobe(drv_strobe), .idx(idx),
        .hs_fall(hs_fall), .cmd_done(cmd_done), .cmd_op(cmd_op)
    );

    dsr_code_tracker #(.HOLD_PERIODS(HOLD_PERIODS)) u_codes (
        .clk(clk), .rst(rst), .period_tick(period_tick),
        .disc_present(disc_present), .cmd_done(cmd_done), .cmd_op(cmd_op),
        .rep_code(rep_code), .drv_code(drv_code)
    );

    dsr_frame_gen #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .en(drv_strobe), .rep_code(rep_code), .idx(idx), .nib(stat_nib)
    );
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
    parameter int FRAME_LEN = 10
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         period_tick,
    input logic                         rdy_req_n,
    input logic                         drv_strobe,
    input logic [3:0]                   stat_nib,
    input logic                         hs_fall,
    input logic [$clog2(FRAME_LEN)-1:0] idx,
    input logic                         cmd_done,
    input logic [3:0]                   cmd_op,
    input logic [3:0]                   rep_code,
    input logic [3:0]                   drv_code
);
    // R2
    req_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_req_n) |-> $past(period_tick));

    // R4
    req_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rdy_req_n && drv_strobe));

    // R4
    nib_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_strobe && !hs_fall) |=> (drv_strobe && $stable(stat_nib)));

    // R5
    csum_nib_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_strobe && 32'(idx) == FRAME_LEN - 1) |-> (stat_nib == ~rep_code));

    // R8
    stop_code_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && cmd_op == 4'h1) |=> (rep_code == 4'h0 && drv_code == 4'h0));

    // R7
    nop_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && cmd_op != 4'h1) |=> (rep_code == $past(drv_code)));

    // R9
    follow_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_code != $past(drv_code) && drv_code != 4'h0) |-> $past(period_tick));
endmodule

bind drv_status_responder dsr_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (.*);

// File: tb/drv_status_responder_bench.sv
module drv_status_responder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_tick = 1'b0;
    logic       disc_present = 1'b0;
    logic       host_strobe = 1'b0;
    logic [3:0] cmd_nib = 4'h0;
    logic       rdy_req_n;
    logic       drv_strobe;
    logic [3:0] stat_nib;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    drv_status_responder u_drv_status_responder (
        .clk(clk), .rst(rst), .period_tick(period_tick),
        .disc_present(disc_present), .host_strobe(host_strobe),
        .cmd_nib(cmd_nib), .rdy_req_n(rdy_req_n),
        .drv_strobe(drv_strobe), .stat_nib(stat_nib)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fall();
        @(negedge clk) host_strobe = 1'b1;
        @(negedge clk) host_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input int exp_req_n, input string req);
        @(negedge clk) period_tick = 1'b1;
        @(negedge clk) period_tick = 1'b0;
        check(req, int'(rdy_req_n), exp_req_n);
    endtask

    task automatic read_frame(input logic [3:0] code, input string req);
        logic [3:0] csum;
        csum = ~code;
        fall();
        check("R4 request released", int'(rdy_req_n), 1);
        check("R4 strobe high", int'(drv_strobe), 1);
        check({req, " nibble0"}, int'(stat_nib), int'(code));
        for (int i = 1; i < 10; i++) begin
            fall();
            if (i < 9) check("R5 fill nibble", int'(stat_nib), 0);
            else check("R5 checksum nibble", int'(stat_nib), int'(csum));
        end
        fall();
        check("R4 frame ended", int'(drv_strobe), 0);
    endtask

    task automatic send_cmd(input logic [3:0] op, input logic [3:0] rest, input logic [3:0] ck);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) cmd_nib = (i == 0) ? op : ((i == 9) ? ck : rest);
            fall();
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdy_req_n after reset", int'(rdy_req_n), 1);
        check("R1 drv_strobe after reset", int'(drv_strobe), 0);
        check("R1 stat_nib after reset", int'(stat_nib), 0);
    endtask

    task automatic t_first_frames();
        tick(0, "R2 first tick request");
        read_frame(4'h0, "R1 reset frame");
        send_cmd(4'h0, 4'h0, 4'hF);
        repeat (20) @(negedge clk);
        check("R2 no request without tick", int'(rdy_req_n), 1);
        tick(0, "R2 tick request");
        read_frame(4'hB, "R7 nop shows no disc");
    endtask

    task automatic t_silence();
        for (int k = 0; k < 3; k++) tick(1, "R3 silent host no request");
        send_cmd(4'h0, 4'h0, 4'hF);
        tick(0, "R3 request after reply");
    endtask

    task automatic t_stall();
        @(negedge clk) host_strobe = 1'b1;
        @(negedge clk) host_strobe = 1'b0;
        @(negedge clk);
        check("R4 first nibble", int'(stat_nib), 4'hB);
        @(negedge clk) host_strobe = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 high strobe no advance", int'(stat_nib), 4'hB);
        check("R4 strobe held", int'(drv_strobe), 1);
        @(negedge clk) host_strobe = 1'b0;
        @(negedge clk);
        check("R4 fall advances", int'(stat_nib), 0);
        for (int i = 2; i < 11; i++) fall();
        check("R4 stalled frame ended", int'(drv_strobe), 0);
    endtask

    task automatic t_stop(input logic disc, input logic [3:0] follow, input string req);
        disc_present = disc;
        send_cmd(4'h1, 4'h0, 4'h3);
        tick(0, "R8 request after stop");
        read_frame(4'h0, "R8 stop reported (R6 bad csum ignored)");
        send_cmd(4'h0, 4'h0, 4'hF);
        tick(0, "R9 request in hold");
        read_frame(4'h0, "R9 still stopped");
        send_cmd(4'h0, 4'h0, 4'hF);
        tick(0, "R9 request after hold");
        read_frame(follow, req);
    endtask

    task automatic t_other_op();
        send_cmd(4'h5, 4'h1, 4'h1);
        tick(0, "R6 request after other op");
        read_frame(4'h9, "R7 other opcode acts as nop");
    endtask

    initial begin
        t_reset();
        t_first_frames();
        t_silence();
        t_stall();
        t_stop(1'b1, 4'h9, "R9 disc present follow");
        t_other_op();
        t_stop(1'b0, 4'hB, "R9 no disc follow");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule